// File: doc/BRIEF.md
# Sequential Read Streamer

This block serves one serial instruction: a continuous read of memory, starting at a given address and running to the end of memory. While chip select is high, it samples one serial input bit on every clock edge. It first expects the opcode 11001011 and then a 16-bit start address. When the parity-enable input is high, one more instruction bit follows the address. The block accepts that bit and does not evaluate it.

After the instruction, the block reads bytes from a synchronous memory port. Each read request is a single-cycle strobe, and the data returns on the following cycle. The bytes go out on the serial output, most significant bit first, with no idle cycle between bytes. The stream stops after the byte at the highest address. When parity is enabled, one extra bit follows the final byte. That bit gives even parity over every data bit sent. Dropping chip select ends the transfer at once and releases the output.

The serial output has an enable signal, which a pad or bus driver uses as its high-impedance control. The memory depth is a parameter. Decoding of other instructions and all write operations belong elsewhere.

Top module: `seq_read_streamer`

## Requirements
- R1: With `cs` high, `di` is sampled on each rising edge. The first 8 bits form the opcode, most significant bit first, and the accepted value is 8'b11001011. The next 16 bits form the start address, also most significant bit first.
- R2: If `pe` is high when the last address bit is sampled, one extra instruction bit is taken after the address. Its value has no effect on the output.
- R3: After any other opcode, `do_oe` stays low until `cs` goes low.
- R4: The first data bit is driven during the cycle that starts two rising edges after the edge that sampled the final instruction bit. Bytes come from consecutive addresses, starting at the start address, and are sent most significant bit first. One bit is sent per cycle, with no gap between bytes.
- R5: The stream ends after the byte at address DEPTH-1, and the address does not wrap. `do_oe` then falls and stays low while `cs` remains high.
- R6: If `pe` is high, exactly one extra bit follows the final byte. Its value is the XOR of every data bit sent in this transfer, so the total number of ones is even.
- R7: If `pe` is low, the final byte is not followed by any extra bit.
- R8: `do_oe` is low out of reset and whenever `cs` is low, with no clock edge needed. A later rising `cs` starts a new instruction.
- R9: If the start address is DEPTH or greater, no data is sent.
- R10: `mem_rd` pulses for one cycle at a time. The read for the next byte is issued while the second-to-last bit of the current byte is being sent. Its data is taken from `mem_rdata` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Chip select; high frames one instruction |
| di | input | 1 | Serial instruction input |
| pe | input | 1 | Parity enable (instruction parity bit and trailing data parity bit) |
| mem_rd | output | 1 | Read strobe to the synchronous memory |
| mem_addr | output | $clog2(DEPTH) | Read address |
| mem_rdata | input | 8 | Read data, valid one cycle after `mem_rd` |
| do_o | output | 1 | Serial data output |
| do_oe | output | 1 | Output enable; low means high impedance |

## Verification
Assertions check several properties on every cycle. The output is never enabled in the cycle after `cs` was low. Memory reads are single pulses, and each prefetch lands on the last bit of a byte. A trailing bit appears only with parity enabled. Byte boundaries inside the stream leave no gap. The address never moves backwards, and the output only drops while `cs` is held when the stream has finished. Several behaviours can only be shown by the bench scenarios, which compare every cycle against a model memory. These are the exact bit order, the value of the accumulated parity bit, the first-bit latency, the rejection of a wrong opcode or an out-of-range address, and recovery after an abort in the middle of a byte.

// File: rtl/seq_read_streamer.sv
module seq_read_streamer #(
  parameter int          DEPTH     = 64,
  parameter int          ADDR_BITS = 16,
  parameter logic [7:0]  OPCODE    = 8'b1100_1011
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cs,
  input  logic                                     di,
  input  logic                                     pe,
  output logic                                     mem_rd,
  output logic [(DEPTH > 1 ? $clog2(DEPTH) : 1)-1:0] mem_addr,
  input  logic [7:0]                               mem_rdata,
  output logic                                     do_o,
  output logic                                     do_oe
);
  localparam int AW = DEPTH > 1 ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(ADDR_BITS) + 1;
  localparam logic [ADDR_BITS-1:0] LAST = ADDR_BITS'(DEPTH - 1);

  typedef enum logic [2:0] {S_OPC, S_ADR, S_PAR, S_FETCH, S_LOAD, S_SHIFT, S_PBIT, S_HALT} st_t;

  st_t                  st;
  logic [CW-1:0]        cnt;
  logic [7:0]           sh;
  logic [ADDR_BITS-1:0] addr;
  logic                 par;

  wire [ADDR_BITS-1:0] addr_in = {addr[ADDR_BITS-2:0], di};
  wire                 in_range = {1'b0, addr_in} < (ADDR_BITS+1)'(DEPTH);
  wire                 at_last  = addr == LAST;
  wire [ADDR_BITS-1:0] addr_nx  = addr + 1'b1;

  assign mem_addr = AW'(st == S_SHIFT ? addr_nx : addr);
  assign mem_rd   = (st == S_FETCH) || (st == S_SHIFT && cnt == CW'(1) && !at_last);
  assign do_oe    = cs && (st == S_SHIFT || st == S_PBIT);
  assign do_o     = do_oe && (st == S_PBIT ? par : sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OPC;
      cnt  <= '0;
      sh   <= '0;
      addr <= '0;
      par  <= 1'b0;
    end else if (!cs) begin
      st  <= S_OPC;
      cnt <= '0;
    end else begin
      case (st)
        S_OPC: begin
          sh  <= {sh[6:0], di};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(7)) begin
            cnt <= '0;
            st  <= ({sh[6:0], di} == OPCODE) ? S_ADR : S_HALT;
          end
        end
        S_ADR: begin
          addr <= addr_in;
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(ADDR_BITS - 1)) begin
            cnt <= '0;
            if (!in_range) st <= S_HALT;
            else           st <= pe ? S_PAR : S_FETCH;
          end
        end
        S_PAR:   st <= S_FETCH;
        S_FETCH: begin
          par <= 1'b0;
          st  <= S_LOAD;
        end
        S_LOAD: begin
          sh  <= mem_rdata;
          cnt <= CW'(7);
          st  <= S_SHIFT;
        end
        S_SHIFT: begin
          par <= par ^ sh[7];
          sh  <= {sh[6:0], 1'b0};
          cnt <= cnt - 1'b1;
          if (cnt == '0) begin
            if (at_last) begin
              st <= pe ? S_PBIT : S_HALT;
            end else begin
              sh   <= mem_rdata;
              addr <= addr_nx;
              cnt  <= CW'(7);
            end
          end
        end
        S_PBIT:  st <= S_HALT;
        default: st <= S_HALT;
      endcase
    end
  end

  a_r8_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> !do_oe);
  a_r10_single_read_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  a_r10_prefetch_on_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && st == S_SHIFT && cs) |=> (st == S_SHIFT && cnt == '0) || !cs);
  a_r4_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && cnt == '0 && !at_last && cs) |=> (do_oe || !cs));
  a_r6_parity_only_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PBIT) |-> pe);
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SHIFT && $past(st == S_SHIFT) && cs && $past(cs)) |-> addr >= $past(addr));
  a_r5_release_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && $past(cs) && $fell(do_oe)) |-> st == S_HALT);
endmodule

// File: tb/test_seq_read_streamer.sv
module test_seq_read_streamer;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, di = 1'b0, pe = 1'b0;
  logic          mem_rd, do_o, do_oe;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata = '0;
  logic [7:0]    mem [DEPTH];
  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  seq_read_streamer #(.DEPTH(DEPTH)) i_seq_read_streamer (
    .clk(clk), .rst_n(rst_n), .cs(cs), .di(di), .pe(pe),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .do_o(do_o), .do_oe(do_oe));

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  task automatic check(input string tag, input int cyc, input logic [1:0] act, input logic [1:0] exp);
    n_checks++;
    if (act[1] !== exp[1] || (exp[1] && act[0] !== exp[0])) begin
      n_fail++;
      $display("FAIL %s cycle %0d: oe,do=%b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic run_txn(input string tag, input logic [7:0] opc, input int start,
                         input logic pe_v, input int abort_at, input int tail);
    logic cmd[$];
    logic [1:0] exp[$];
    logic p = 1'b0;
    logic prev_rd = 1'b0;
    int n;
    for (int b = 7; b >= 0; b--) cmd.push_back(opc[b]);
    for (int b = 15; b >= 0; b--) cmd.push_back(start[b]);
    if (pe_v) cmd.push_back(1'b1);
    for (int i = 0; i < cmd.size() + 1; i++) exp.push_back(2'b00);
    if (opc == 8'hCB && start < DEPTH) begin
      for (int a = start; a < DEPTH; a++)
        for (int b = 7; b >= 0; b--) begin
          exp.push_back({1'b1, mem[a][b]});
          p ^= mem[a][b];
        end
      if (pe_v) exp.push_back({1'b1, p});
    end
    for (int i = 0; i < tail; i++) exp.push_back(2'b00);
    n = (abort_at >= 0) ? abort_at : exp.size();
    @(negedge clk);
    pe = pe_v; cs = 1'b1; di = cmd[0];
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag, i, {do_oe, do_o}, exp[i]);
      n_checks++;
      if (mem_rd && prev_rd) begin
        n_fail++;
        $display("FAIL R10 cycle %0d: mem_rd=11 expected single pulse", i);
      end
      prev_rd = mem_rd;
      di = (i + 1 < cmd.size()) ? cmd[i + 1] : 1'b0;
    end
    cs = 1'b0;
    #1;
    check("R8", -1, {do_oe, do_o}, 2'b00);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < DEPTH; a++) mem[a] = 8'((a * 53 + 29) ^ (a * a));
    repeat (3) @(negedge clk);
    check("R8", -2, {do_oe, do_o}, 2'b00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R4 R5 R7: tail end of memory, no parity
    run_txn("R5", 8'hCB, DEPTH - 3, 1'b0, -1, 6);
    // R2 R6: same with trailing parity
    run_txn("R6", 8'hCB, DEPTH - 3, 1'b1, -1, 6);
    // R4 R6: whole memory
    run_txn("R4", 8'hCB, 0, 1'b1, -1, 4);
    // R7 R1: mid start, no parity
    run_txn("R7", 8'hCB, 40, 1'b0, -1, 4);
    // R3: wrong opcode
    run_txn("R3", 8'hCA, 10, 1'b0, 60, 0);
    // R9: start beyond memory
    run_txn("R9", 8'hCB, DEPTH, 1'b1, -1, 40);
    run_txn("R9", 8'hCB, 16'hFFFF, 1'b0, -1, 40);
    // R8: abort in middle of the second byte, then a fresh instruction
    run_txn("R8", 8'hCB, 5, 1'b1, 25 + 1 + 12, 0);
    run_txn("R8", 8'hCB, DEPTH - 2, 1'b1, -1, 5);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule